// File: doc/BRIEF.md
# Codirectional 64 kbit/s Transmit Encoder

This block takes one eight-bit octet from a chosen time-slot of a 2.048 MHz PCM bus and turns it into a continuous 64 kbit/s codirectional line signal. The signal leaves on two active-low rails, one per line polarity. The PCM bit clock and the 256 kHz unit-interval clock are both given as single-cycle enables inside one system clock domain. A one-octet storage latch sits between the capture side and the line side, so the two rates may drift apart. When they slip, an octet is either dropped or sent twice, and a flag is raised for each case.

Each data bit fills four unit intervals. A bit's four intervals form one block, and consecutive blocks take alternating line polarity. The eighth block of every octet repeats the polarity of the seventh. This deliberate violation marks octet timing for the far end. While the alarm input is high, the violation is suppressed and plain alternation carries on.

Top module: `codir_tx_encoder`

## Requirements
- R1: The capture strobe is `slotA` when `slotSel` is 1 and `slotB` when `slotSel` is 0; activity on the strobe that is not selected has no effect on what is transmitted.
- R2: On each `pcmEn` cycle with the selected strobe high, one bit of `pcmData` is captured; eight such bits form an octet, and the first captured bit is the first one transmitted. A strobe low cycle restarts the bit count.
- R3: Each `lineEn` pulse is one unit interval, and the rails update in the cycle after it and at no other time. An octet lasts 32 unit intervals (8 bits of 4). Octet framing starts at the first `lineEn` after reset and runs freely.
- R4: Within a bit's block, unit interval 0 is always a mark; interval 1 is a mark for data 1 and interval 2 is a mark for data 0; interval 3 is never a mark. A mark drives exactly one rail low; the two rails are never low together.
- R5: Consecutive blocks alternate polarity. The first block sent after reset is on the positive rail (`txPosN`).
- R6: With `alarmIn` low during an octet's eighth block, that block has the same polarity as the seventh.
- R7: With `alarmIn` high during the eighth block, that block alternates like any other.
- R8: A captured octet waits in the latch and starts only at the next octet boundary; an octet in progress is never changed.
- R9: If a new octet is captured while the latch still holds one not yet started, the latch is overwritten and `deleteFlag` is high for the next 32 unit intervals.
- R10: At a boundary with no new octet, the last octet is sent once more and `insertFlag` is high for that whole octet period; a second consecutive repeat never happens.
- R11: At a boundary with no new octet and the repeat already used (or nothing ever sent), both rails stay high for the octet. Block polarity history is kept across idle octets.
- R12: After reset both rails are high and both flags are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pcmEn | input | 1 | PCM bit-clock enable (capture edge) |
| pcmData | input | 1 | Serial PCM data |
| slotA | input | 1 | First time-slot strobe |
| slotB | input | 1 | Second time-slot strobe |
| slotSel | input | 1 | Strobe select: 1 picks slotA, 0 picks slotB |
| lineEn | input | 1 | Unit-interval enable (256 kHz) |
| alarmIn | input | 1 | High suppresses the octet violation |
| txPosN | output | 1 | Positive-polarity mark rail, active low |
| txNegN | output | 1 | Negative-polarity mark rail, active low |
| insertFlag | output | 1 | High during a repeated octet |
| deleteFlag | output | 1 | High for 32 unit intervals after an overwrite |

## Verification
Assertions check several properties on every cycle. The rails are never low together and move only after a unit-interval pulse. Interval 3 of each block and idle octets stay quiet. An overwrite of a full latch raises the delete flag, the insert flag changes only at octet boundaries, and a pending latch is never lost between boundaries. The other behaviours can only be shown by the bench's scenarios: the exact mark pattern per data bit, the polarity sequence with and without violations, the order of bits, which octet is chosen at each boundary, and that a decoy burst on the unselected strobe is ignored. To show these, the bench decodes whole octets on the rails against a model of the requirements.

// File: rtl/codir_pkg.sv
package codir_pkg;
  localparam int OCTET_BITS = 8;
  localparam int UI_PER_BIT = 4;
  localparam int OCTET_UI   = OCTET_BITS * UI_PER_BIT;
  localparam int BIT_W      = $clog2(OCTET_BITS);
  localparam int UI_W       = $clog2(UI_PER_BIT);
  localparam int DEL_W      = $clog2(OCTET_UI + 1);

  typedef struct packed {
    logic            capShift;
    logic            capDone;
    logic            lineTick;
    logic            blockStart;
    logic            lastBlock;
    logic            loadNew;
    logic            sending;
    logic [UI_W-1:0] uiIdx;
    logic [BIT_W-1:0] bitIdx;
  } ctrl_t;
endpackage

// File: rtl/codir_tx_ctrl.sv
module codir_tx_ctrl
  import codir_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  pcmEn,
  input  logic  slotA,
  input  logic  slotB,
  input  logic  slotSel,
  input  logic  lineEn,
  output ctrl_t ctl,
  output logic  insertFlag,
  output logic  deleteFlag
);
  logic             selStrobe;
  logic [BIT_W-1:0] capCnt;
  logic             latchValid;
  logic             haveLast;
  logic             repUsed;
  logic             activeQ;
  logic             insertQ;
  logic [UI_W-1:0]  uiCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [DEL_W-1:0] delCnt;
  logic             boundary;
  logic             capShift;
  logic             capDone;
  logic             loadNew;
  logic             takeRepeat;
  logic             dropEvt;

  assign selStrobe  = slotSel ? slotA : slotB;
  assign boundary   = lineEn && (uiCnt == '0) && (bitCnt == '0);
  assign capShift   = pcmEn && selStrobe;
  assign capDone    = capShift && (capCnt == BIT_W'(OCTET_BITS - 1));
  assign loadNew    = boundary && latchValid;
  assign takeRepeat = boundary && !latchValid && haveLast && !repUsed;
  assign dropEvt    = capDone && latchValid && !loadNew;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capCnt <= '0;
    end else if (!selStrobe) begin
      capCnt <= '0;
    end else if (capShift) begin
      capCnt <= capDone ? '0 : capCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchValid <= 1'b0;
      haveLast   <= 1'b0;
      repUsed    <= 1'b0;
      activeQ    <= 1'b0;
      insertQ    <= 1'b0;
    end else begin
      if (capDone)      latchValid <= 1'b1;
      else if (loadNew) latchValid <= 1'b0;
      if (loadNew) begin
        haveLast <= 1'b1;
        repUsed  <= 1'b0;
      end else if (takeRepeat) begin
        repUsed  <= 1'b1;
      end
      if (boundary) begin
        activeQ <= loadNew || takeRepeat;
        insertQ <= takeRepeat;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      uiCnt  <= '0;
      bitCnt <= '0;
    end else if (lineEn) begin
      if (uiCnt == UI_W'(UI_PER_BIT - 1)) begin
        uiCnt  <= '0;
        bitCnt <= (bitCnt == BIT_W'(OCTET_BITS - 1)) ? '0 : bitCnt + 1'b1;
      end else begin
        uiCnt <= uiCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delCnt <= '0;
    end else if (dropEvt) begin
      delCnt <= DEL_W'(OCTET_UI);
    end else if (lineEn && (delCnt != '0)) begin
      delCnt <= delCnt - 1'b1;
    end
  end

  always_comb begin
    ctl            = '0;
    ctl.capShift   = capShift;
    ctl.capDone    = capDone;
    ctl.lineTick   = lineEn;
    ctl.blockStart = lineEn && (uiCnt == '0);
    ctl.lastBlock  = (bitCnt == BIT_W'(OCTET_BITS - 1));
    ctl.loadNew    = loadNew;
    ctl.sending    = boundary ? (loadNew || takeRepeat) : activeQ;
    ctl.uiIdx      = uiCnt;
    ctl.bitIdx     = bitCnt;
  end

  assign insertFlag = insertQ;
  assign deleteFlag = (delCnt != '0);

  // R9: overwriting an unsent latch raises the delete flag
  assert_overwrite_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    (capDone && latchValid && !boundary) |=> deleteFlag);

  // R10: the insert flag only moves at an octet boundary
  assert_insert_steady_R10: assert property (@(posedge clk) disable iff (!rstN)
    !boundary |=> $stable(insertFlag));

  // R10: no second repeat in a row
  assert_repeat_once_R10: assert property (@(posedge clk) disable iff (!rstN)
    (insertFlag && boundary && !latchValid) |=> !insertFlag);

  // R8: a pending octet is kept until a boundary takes it
  assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (latchValid && !boundary) |=> latchValid);
endmodule

// File: rtl/codir_tx_dp.sv
module codir_tx_dp
  import codir_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  pcmData,
  input  logic  alarmIn,
  input  ctrl_t ctl,
  output logic  txPosN,
  output logic  txNegN
);
  logic [OCTET_BITS-1:0] capReg;
  logic [OCTET_BITS-1:0] latchReg;
  logic [OCTET_BITS-1:0] sendReg;
  logic [OCTET_BITS-1:0] newByte;
  logic [OCTET_BITS-1:0] curByte;
  logic [BIT_W-1:0]      bitSel;
  logic                  curBit;
  logic                  polQ;     // polarity of the latest block, 1 = negative
  logic                  startPol;
  logic                  blockPol;
  logic                  chipOn;
  logic                  markOn;

  assign newByte  = {capReg[OCTET_BITS-2:0], pcmData};
  assign curByte  = ctl.loadNew ? latchReg : sendReg;
  assign bitSel   = BIT_W'(OCTET_BITS - 1) - ctl.bitIdx;
  assign curBit   = curByte[bitSel];
  assign startPol = (ctl.lastBlock && !alarmIn) ? polQ : !polQ;
  assign blockPol = ctl.blockStart ? startPol : polQ;

  always_comb begin
    case (ctl.uiIdx)
      UI_W'(0): chipOn = 1'b1;
      UI_W'(1): chipOn = curBit;
      UI_W'(2): chipOn = !curBit;
      default:  chipOn = 1'b0;
    endcase
  end

  assign markOn = ctl.sending && chipOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capReg   <= '0;
      latchReg <= '0;
      sendReg  <= '0;
    end else begin
      if (ctl.capShift) capReg   <= newByte;
      if (ctl.capDone)  latchReg <= newByte;
      if (ctl.loadNew)  sendReg  <= latchReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polQ   <= 1'b1;
      txPosN <= 1'b1;
      txNegN <= 1'b1;
    end else if (ctl.lineTick) begin
      if (ctl.blockStart && ctl.sending) polQ <= startPol;
      txPosN <= !(markOn && !blockPol);
      txNegN <= !(markOn && blockPol);
    end
  end

  // R4: one rail at most carries a mark
  assert_rails_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    txPosN || txNegN);

  // R3: rails move only after a unit-interval pulse
  assert_rail_timing_R3: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.lineTick |=> $stable({txPosN, txNegN}));

  // R4: the last interval of every block is quiet
  assert_quiet_ui_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.lineTick && ctl.uiIdx == UI_W'(UI_PER_BIT - 1)) |=> (txPosN && txNegN));

  // R11: an idle octet keeps both rails high
  assert_idle_high_R11: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.lineTick && !ctl.sending) |=> (txPosN && txNegN));
endmodule

// File: rtl/codir_tx_encoder.sv
module codir_tx_encoder
  import codir_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic pcmEn,
  input  logic pcmData,
  input  logic slotA,
  input  logic slotB,
  input  logic slotSel,
  input  logic lineEn,
  input  logic alarmIn,
  output logic txPosN,
  output logic txNegN,
  output logic insertFlag,
  output logic deleteFlag
);
  ctrl_t ctl;

  codir_tx_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pcmEn      (pcmEn),
    .slotA      (slotA),
    .slotB      (slotB),
    .slotSel    (slotSel),
    .lineEn     (lineEn),
    .ctl        (ctl),
    .insertFlag (insertFlag),
    .deleteFlag (deleteFlag)
  );

  codir_tx_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pcmData (pcmData),
    .alarmIn (alarmIn),
    .ctl     (ctl),
    .txPosN  (txPosN),
    .txNegN  (txNegN)
  );
endmodule

// File: tb/sim_codir_tx_encoder.sv
module sim_codir_tx_encoder;
  localparam int NSLOT = 40;
  localparam int TPO   = 32;   // unit intervals per octet
  localparam int CPT   = 4;    // clocks per unit interval

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pcmEn = 1'b0, pcmData = 1'b0, slotA = 1'b0, slotB = 1'b0;
  logic slotSel = 1'b0, lineEn = 1'b0, alarmIn = 1'b0;
  logic txPosN, txNegN, insertFlag, deleteFlag;

  always #10 clk = ~clk;

  codir_tx_encoder u0 (
    .clk(clk), .rstN(rstN), .pcmEn(pcmEn), .pcmData(pcmData),
    .slotA(slotA), .slotB(slotB), .slotSel(slotSel), .lineEn(lineEn),
    .alarmIn(alarmIn), .txPosN(txPosN), .txNegN(txNegN),
    .insertFlag(insertFlag), .deleteFlag(deleteFlag)
  );

  int   nB[NSLOT];
  int   offA[NSLOT];
  logic [7:0] bA[NSLOT], bB[NSLOT], dec[NSLOT];
  bit   selA[NSLOT], alm[NSLOT], hasDecoy[NSLOT];

  int tests = 0, fails = 0;
  bit done = 1'b0;

  // expected model state
  int   mode;            // 0 idle, 1 new octet, 2 repeat
  logic [7:0] expByte;
  bit   haveLast = 0, repUsed = 0, prevPol = 1, curPol = 0;
  int   slotErr, errTick, errAct, errExp;

  task automatic check(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] railsFor(bit mark, bit pol);
    return {!(mark && !pol), !(mark && pol)};
  endfunction

  function automatic bit chipMark(logic [7:0] b8, int bitNo, int ui);
    bit d;
    d = b8[7 - bitNo];
    case (ui)
      0: return 1'b1;
      1: return d;
      2: return !d;
      default: return 1'b0;
    endcase
  endfunction

  task automatic sampleTick(int t);
    int s, pos, b, ui;
    logic [1:0] exp2;
    string tag;
    s = t / TPO; pos = t % TPO; b = pos / 4; ui = pos % 4;
    if (pos == 0) begin
      slotErr = 0;
      if (s > 0 && nB[s-1] > 0) begin
        mode = 1;
        expByte = (nB[s-1] == 2) ? bB[s-1] : bA[s-1];
        haveLast = 1; repUsed = 0;
      end else if (haveLast && !repUsed) begin
        mode = 2; repUsed = 1;
      end else begin
        mode = 0;
      end
    end
    if (mode != 0 && ui == 0) begin
      curPol = (b == 7 && !alm[s]) ? prevPol : !prevPol;
      prevPol = curPol;
    end
    exp2 = railsFor(mode != 0 && chipMark(expByte, b, ui), curPol);
    if ({txPosN, txNegN} !== exp2 && slotErr == 0) begin
      slotErr = 1; errTick = pos; errAct = {txPosN, txNegN}; errExp = exp2;
    end
    if (pos == 2) begin
      check(insertFlag === (mode == 2), $sformatf("R10 insert flag slot %0d", s),
            insertFlag, mode == 2);
      check(deleteFlag === (s > 0 && nB[s-1] == 2),
            $sformatf("R9 delete flag slot %0d", s), deleteFlag, s > 0 && nB[s-1] == 2);
    end
    if (pos == TPO - 1) begin
      if (mode == 0)      tag = "R11 idle rails";
      else if (mode == 2) tag = "R10 repeated octet rails";
      else if (alm[s])    tag = "R7 alarm octet rails";
      else                tag = "R6 violation octet rails";
      if (s > 0 && hasDecoy[s-1]) tag = {tag, " R1 decoy ignored"};
      tag = {tag, " R2 R3 R4 R5 R8"};
      check(slotErr == 0, $sformatf("%s slot %0d ui %0d", tag, s, errTick), errAct, errExp);
    end
  endtask

  task automatic driveCycle(int cyc);
    int t, w, o, sc;
    bit inBurst, inDecoy;
    logic [7:0] cur;
    int idx;
    t = cyc / CPT; w = t / TPO; o = 0;
    lineEn  = (cyc % CPT == 0);
    alarmIn = alm[w];
    slotSel = selA[w];
    inBurst = 0; inDecoy = 0; cur = 8'h00; idx = 0;
    for (int k = 0; k < nB[w]; k++) begin
      o  = (nB[w] == 2) ? (k == 0 ? 8 : 20) : offA[w];
      sc = (TPO * w + o) * CPT + 1;
      if (cyc >= sc && cyc < sc + 8) begin
        inBurst = 1; cur = (k == 0) ? bA[w] : bB[w]; idx = cyc - sc;
      end
    end
    sc = (TPO * w + 14) * CPT + 1;
    if (hasDecoy[w] && cyc >= sc && cyc < sc + 8) begin
      inDecoy = 1; cur = dec[w]; idx = cyc - sc;
    end
    if (inBurst) begin
      pcmEn = 1; pcmData = cur[7 - idx];
      slotA = selA[w]; slotB = !selA[w];
    end else if (inDecoy) begin
      pcmEn = 1; pcmData = cur[7 - idx];
      slotA = !selA[w]; slotB = selA[w];
    end else begin
      pcmEn = 1'($urandom); pcmData = 1'($urandom);
      slotA = 0; slotB = 0;
    end
  endtask

  initial begin
    int unsigned seedv;
    seedv = $urandom(32'd4242);
    for (int w = 0; w < NSLOT; w++) begin
      nB[w]  = int'($urandom % 3);
      offA[w] = ($urandom % 2) ? 8 : 20;
      bA[w]  = 8'($urandom); bB[w] = 8'($urandom); dec[w] = 8'($urandom);
      selA[w] = 1'($urandom); alm[w] = (($urandom % 4) == 0);
      hasDecoy[w] = (($urandom % 3) == 0);
    end
    // directed opening: new, new with decoy, repeat, idle, overwrite, repeat
    nB[0] = 1; bA[0] = 8'b1011_0001; offA[0] = 8;  alm[0] = 0; alm[1] = 0;
    nB[1] = 1; bA[1] = 8'h5A; hasDecoy[1] = 1; dec[1] = 8'hFF; selA[1] = 0;
    nB[2] = 0; nB[3] = 0;
    nB[4] = 2; bA[4] = 8'h0F; bB[4] = 8'hC3;
    nB[5] = 0; alm[5] = 1;
    nB[6] = 1; bA[6] = 8'h00; alm[7] = 1;
    nB[NSLOT-1] = 0;

    repeat (3) @(negedge clk);
    check(txPosN === 1'b1 && txNegN === 1'b1, "R12 rails idle in reset",
          {txPosN, txNegN}, 3);
    check(insertFlag === 1'b0 && deleteFlag === 1'b0, "R12 flags low in reset",
          {insertFlag, deleteFlag}, 0);
    rstN = 1'b1;
    for (int cyc = 0; cyc < NSLOT * TPO * CPT + 1; cyc++) begin
      if (cyc % CPT == 1) sampleTick((cyc - 1) / CPT);
      if (cyc < NSLOT * TPO * CPT) driveCycle(cyc);
      else begin lineEn = 0; pcmEn = 0; slotA = 0; slotB = 0; end
      @(negedge clk);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule